// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square integer matrices on a grid of N×N multiply-accumulate cells. Each cell owns one element of the result and keeps it in a local 32-bit sum. Left-matrix values travel rightward along the rows, and right-matrix values travel downward along the columns. Every value enters the grid once and then serves all N cells on its path.

The caller pulses `start` and presents one operand slice on that same edge. It then presents one slice per cycle for the next N−1 cycles. The block delays row lane i by i cycles and column lane j by j cycles internally, so that matching pairs meet in cell (i,j). Outside the feed window, the operand lanes are forced to zero. Once the grid has drained, the block shifts the result out one row per cycle while `done` is high, and then returns to idle.

Top module: `systolic_matmul`

## Requirements
- R1: Each result element equals the sum over k of A[i][k]·B[k][j]. Operands are 8-bit two's complement values and the sum is a 32-bit two's complement value that wraps.
- R2: A run begins on a clock edge where `start` is high and the block is idle. Slice k=0 is sampled on that edge, and slices k=1..N−1 on the following N−1 edges. Lane i of `aCol` (bits [8i+7:8i]) carries A[i][k], and lane j of `bRow` (bits [8j+7:8j]) carries B[k][j].
- R3: The start edge is edge 0. `done` rises on edge 3N−2 and stays high for exactly N cycles.
- R4: While `done` is high, `rowIdx` counts 0,1,…,N−1, one step per cycle. Lane j of `resRow` (bits [32j+31:32j]) then holds C[rowIdx][j].
- R5: While `done` is low, `resRow` and `rowIdx` are zero.
- R6: `busy` is high from the start edge through the last unload cycle (edges 0 to 4N−3) and low otherwise.
- R7: A `start` pulse while `busy` is high is ignored. It changes neither the timing nor the results of the run in progress.
- R8: Operand values presented outside the N-cycle feed window have no effect on any result.
- R9: Each accepted start clears all sums, so back-to-back runs are independent.
- R10: During and straight after reset, `busy` and `done` are low and `resRow` and `rowIdx` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| aCol | input | N*8 | Left-matrix column slice, lane i = A[i][k] |
| bRow | input | N*8 | Right-matrix row slice, lane j = B[k][j] |
| busy | output | 1 | A run is feeding, draining or unloading |
| done | output | 1 | A result row is valid on `resRow` |
| rowIdx | output | clog2(N) | Index of the row currently shown |
| resRow | output | N*32 | One result row, lane j = C[rowIdx][j] |

## Verification
Two functions can fall in the same cycle: a fresh `start` request and the unloading (or draining) of the run in progress. The bench provokes this by toggling `start` at random on every busy cycle, including the last unload edge. It judges the outcome by requiring that `done` still rises on edge 3N−2, that every row still matches the product computed by the bench, and that `busy` falls on schedule. Garbage on the operand lanes outside the feed window also overlaps the drain and the unload, and it is judged the same way.

// File: rtl/smm_pkg.sv
package smm_pkg;
  // Strobes from the sequencer into the grid datapath
  typedef struct packed {
    logic clr;    // zero every sum on this edge
    logic feed;   // operand lanes are live this edge
    logic shift;  // move sums one row up this edge
  } smm_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_UNLOAD = 2'd2
  } smm_state_e;
endpackage

// File: rtl/smm_skew.sv
module smm_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < DEPTH; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < DEPTH; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/smm_mac.sv
module smm_mac #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clr,
  input  logic                 shift,
  input  logic signed [DW-1:0] aIn,
  input  logic signed [DW-1:0] bIn,
  input  logic        [AW-1:0] shiftIn,
  output logic        [AW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic        [AW-1:0] prodExt;
  logic        [AW-1:0] base;

  assign prod    = aIn * bIn;
  assign prodExt = {{(AW-PW){prod[PW-1]}}, prod};
  assign base    = clr ? '0 : acc;

  always_ff @(posedge clk) begin
    if (!rstN)      acc <= '0;
    else if (shift) acc <= shiftIn;
    else            acc <= base + prodExt;
  end
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output smm_strobe_t          strb,
  output logic                 busy,
  output logic                 done,
  output logic [$clog2(N)-1:0] rowIdx
);
  localparam int RW       = $clog2(N);
  localparam int LAST_RUN = 3 * N - 2;
  localparam int CW       = $clog2(LAST_RUN + 1);

  smm_state_e      state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= CW'(1);
        end
        ST_RUN: if (cnt == CW'(LAST_RUN)) begin
          state <= ST_UNLOAD;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_UNLOAD: if (cnt == CW'(N - 1)) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strb.clr   = (state == ST_IDLE) && start;
    strb.feed  = strb.clr || ((state == ST_RUN) && (cnt < CW'(N)));
    strb.shift = (state == ST_UNLOAD);
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_UNLOAD);
  assign rowIdx = done ? RW'(cnt) : '0;

  // R7: once running, the count only advances; a start cannot rewind it
  p_run_advances_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> ((state == ST_RUN) && (cnt == $past(cnt) + 1'b1)) ||
                          ((state == ST_UNLOAD) && (cnt == '0)));

  // R3: unloading opens with row 0 and only after the run phase
  p_row_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (rowIdx == '0) && busy);

  // R4: rows leave in order, one per cycle, without gaps
  p_row_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && (rowIdx != RW'(N - 1))) |=> done && (rowIdx == $past(rowIdx) + 1'b1));
endmodule

// File: rtl/smm_grid.sv
module smm_grid
  import smm_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  smm_strobe_t     strb,
  input  logic [N*DW-1:0] aLane,
  input  logic [N*DW-1:0] bLane,
  output logic [N*AW-1:0] rowOut
);
  logic [DW-1:0] aGate [N];
  logic [DW-1:0] bGate [N];
  logic [DW-1:0] aSk   [N];
  logic [DW-1:0] bSk   [N];
  logic [DW-1:0] aAt   [N][N];
  logic [DW-1:0] bAt   [N][N];
  logic [DW-1:0] aFwd  [N][N-1];
  logic [DW-1:0] bFwd  [N-1][N];
  logic [AW-1:0] acc   [N][N];
  logic [AW-1:0] shIn  [N][N];
  logic          anyLive;

  for (genvar gl = 0; gl < N; gl++) begin : g_lane
    // idle lanes carry zeros so nothing stale lands in a sum
    assign aGate[gl] = strb.feed ? aLane[gl*DW +: DW] : '0;
    assign bGate[gl] = strb.feed ? bLane[gl*DW +: DW] : '0;
    if (gl == 0) begin : g_noSkew
      assign aSk[gl] = aGate[gl];
      assign bSk[gl] = bGate[gl];
    end else begin : g_skew
      smm_skew #(.W(DW), .DEPTH(gl)) u_aSkew (
        .clk(clk), .rstN(rstN), .din(aGate[gl]), .dout(aSk[gl]));
      smm_skew #(.W(DW), .DEPTH(gl)) u_bSkew (
        .clk(clk), .rstN(rstN), .din(bGate[gl]), .dout(bSk[gl]));
    end
    assign rowOut[gl*AW +: AW] = acc[0][gl];
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gj == 0) begin : g_aEdge
        assign aAt[gi][gj] = aSk[gi];
      end else begin : g_aInner
        assign aAt[gi][gj] = aFwd[gi][gj-1];
      end
      if (gi == 0) begin : g_bEdge
        assign bAt[gi][gj] = bSk[gj];
      end else begin : g_bInner
        assign bAt[gi][gj] = bFwd[gi-1][gj];
      end
      if (gj < N - 1) begin : g_aReg
        always_ff @(posedge clk) begin
          if (!rstN) aFwd[gi][gj] <= '0;
          else       aFwd[gi][gj] <= aAt[gi][gj];
        end
      end
      if (gi < N - 1) begin : g_bReg
        always_ff @(posedge clk) begin
          if (!rstN) bFwd[gi][gj] <= '0;
          else       bFwd[gi][gj] <= bAt[gi][gj];
        end
        assign shIn[gi][gj] = acc[gi+1][gj];
      end else begin : g_bottom
        assign shIn[gi][gj] = '0;
      end

      smm_mac #(.DW(DW), .AW(AW)) u_mac (
        .clk    (clk),
        .rstN   (rstN),
        .clr    (strb.clr),
        .shift  (strb.shift),
        .aIn    (aAt[gi][gj]),
        .bIn    (bAt[gi][gj]),
        .shiftIn(shIn[gi][gj]),
        .acc    (acc[gi][gj])
      );
    end
  end

  always_comb begin
    anyLive = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        anyLive = anyLive | (|aAt[i][j]) | (|bAt[i][j]);
  end

  // R8: by the time rows shift out, every operand has left the cells
  p_quiet_unload_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> !anyLive);

  // R9: the far corner starts each run from a cleared sum
  p_clear_far_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (acc[N-1][N-1] == '0));
endmodule

// File: rtl/systolic_matmul.sv
module systolic_matmul #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [N*DW-1:0]      aCol,
  input  logic [N*DW-1:0]      bRow,
  output logic                 busy,
  output logic                 done,
  output logic [$clog2(N)-1:0] rowIdx,
  output logic [N*AW-1:0]      resRow
);
  smm_pkg::smm_strobe_t strb;
  logic [N*AW-1:0]      rowOut;

  smm_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done),
    .rowIdx(rowIdx)
  );

  smm_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .aLane (aCol),
    .bLane (bRow),
    .rowOut(rowOut)
  );

  assign resRow = done ? rowOut : '0;

  // R5: the result port is silent whenever no row is offered
  p_quiet_port_r5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (resRow == '0) && (rowIdx == '0));
endmodule

// File: tb/systolic_matmul_bench.sv
module systolic_matmul_bench;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = 32;
  localparam int RW = $clog2(N);

  logic            clk = 1'b0;
  logic            rstN;
  logic            start;
  logic [N*DW-1:0] aCol;
  logic [N*DW-1:0] bRow;
  logic            busy;
  logic            done;
  logic [RW-1:0]   rowIdx;
  logic [N*AW-1:0] resRow;

  int nChecks = 0;
  int nFails  = 0;
  int mA [N][N];
  int mB [N][N];
  int mC [N][N];

  always #10 clk = ~clk;

  systolic_matmul #(.N(N), .DW(DW), .AW(AW)) u_systolic_matmul (
    .clk(clk), .rstN(rstN), .start(start), .aCol(aCol), .bRow(bRow),
    .busy(busy), .done(done), .rowIdx(rowIdx), .resRow(resRow));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clip8(input int v);
    return int'($signed(8'(v)));
  endfunction

  // R1: expected product with 32-bit wrap (int arithmetic wraps the same way)
  function automatic void computeProduct();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int s = 0;
        for (int k = 0; k < N; k++) s += mA[i][k] * mB[k][j];
        mC[i][j] = s;
      end
  endfunction

  function automatic void fill(input int mode);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        case (mode)
          1: begin mA[i][j] = -128; mB[i][j] = -128; end
          2: begin mA[i][j] = (i == j) ? 1 : 0; mB[i][j] = clip8($urandom); end
          3: begin mA[i][j] = 127; mB[i][j] = -128; end
          4: begin
            mA[i][j] = ($urandom_range(0, 1) != 0) ? 127 : -128;
            mB[i][j] = ($urandom_range(0, 1) != 0) ? -128 : 127;
          end
          default: begin mA[i][j] = clip8($urandom); mB[i][j] = clip8($urandom); end
        endcase
      end
  endfunction

  // One run, edge by edge; called at a falling edge with the block idle.
  task automatic runCase(input int mode, input bit noisy);
    fill(mode);
    computeProduct();
    for (int c = 0; c <= 4 * N - 1; c++) begin
      bit expDone;
      // R2: slice k drives lanes on edge k; R7: random start while busy
      if (c == 0)                        start = 1'b1;
      else if (noisy && c <= 4 * N - 2)  start = 1'($urandom_range(0, 1));
      else                               start = 1'b0;
      for (int l = 0; l < N; l++) begin
        // R8: garbage on the lanes outside the feed window
        aCol[l*DW +: DW] = (c < N) ? DW'(mA[l][c]) : DW'($urandom);
        bRow[l*DW +: DW] = (c < N) ? DW'(mB[c][l]) : DW'($urandom);
      end
      @(negedge clk);
      expDone = (c >= 3 * N - 2) && (c <= 4 * N - 3);
      chk(busy == (c <= 4 * N - 3), "R6 busy", busy, (c <= 4 * N - 3));
      chk(done == expDone, "R3 done timing", done, expDone);
      if (expDone) begin
        int r = c - (3 * N - 2);
        chk(rowIdx == RW'(r), "R4 row index", rowIdx, r);
        for (int j = 0; j < N; j++) begin
          int got = int'($signed(resRow[j*AW +: AW]));
          chk(got == mC[r][j], "R1 R9 result element", got, mC[r][j]);
        end
      end else begin
        chk(resRow == '0, "R5 idle result lanes", (resRow != '0), 0);
        chk(rowIdx == '0, "R5 idle row index", rowIdx, 0);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    rstN  = 1'b0;
    start = 1'b0;
    aCol  = '0;
    bRow  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0, "R10 busy in reset", busy, 0);
    chk(done == 1'b0, "R10 done in reset", done, 0);
    chk(resRow == '0, "R10 result in reset", (resRow != '0), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 idle after reset", {busy, done}, 0);

    runCase(2, 1'b0);           // identity left operand
    runCase(1, 1'b0);           // most negative everywhere
    runCase(3, 1'b1);           // opposite extremes, noisy start
    runCase(4, 1'b1);           // mixed extremes, noisy start
    for (int t = 0; t < 6; t++) runCase(0, (t % 2) == 1);  // R9 back to back

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule